// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps one lock reservation for a single requester. The reservation lets a load-linked and a later store-conditional act as one atomic pair. The block watches the completion stream of memory requests. Each completion carries a byte address, a request kind and a flag that says whether the line is resident in the cache. For each completion it decides whether to set, keep or drop the reservation. It also decides whether the request succeeded, which only matters for a store-conditional. A second input reports that coherence permission for a line has been lost, and that report can arrive in any cycle, with or without a completion.

The reservation is one valid bit plus a cache-line number. The line number is the byte address with its low line-offset bits removed. A completion in cycle N produces a one-cycle response in cycle N+1. The reservation outputs also change in cycle N+1. A loss-of-permission event is applied before a completion in the same cycle. Because of this order, a store-conditional that races a permission loss on its own line fails.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, `lock_valid`, `rsp_valid` and `rsp_ok` are all 0.
- R2: A completion of kind 3 (load-linked) whose line is present sets `lock_valid` to 1 and `lock_line` to its line. This replaces any earlier reservation, and the response is a success (`rsp_ok`=1).
- R3: A completion of kind 4 (store-conditional) whose line is present reports `rsp_ok`=1 only if a reservation on its line survives that cycle, and reports 0 otherwise.
- R4: A store-conditional (kind 4) whose line is present clears a reservation on its own line, whether it succeeds or fails. A reservation on a different line is kept.
- R5: Completions of kinds 2, 5, 6 and 7 (plain store, read-for-ownership, locked write, flush) whose line is present clear a reservation on their own line. They leave a reservation on another line untouched, and they report `rsp_ok`=1.
- R6: A loss-of-permission event on the reserved line clears the reservation. An event on any other line has no effect. The event is applied before a completion in the same cycle.
- R7: A completion with `cmp_present`=0 reports `rsp_ok`=1 and changes no reservation state, whatever its kind.
- R8: Completions of kinds 0 and 1 (load, instruction fetch) neither set nor clear the reservation, and they report `rsp_ok`=1.
- R9: `rsp_valid` is 1 exactly in the cycle after each `cmp_valid`. `rsp_ok` is 0 whenever `rsp_valid` is 0.
- R10: Addresses are compared by line only. The low log2(LINE_BYTES) bits (4 at the default) do not affect any match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | A request completes this cycle |
| cmp_addr | input | ADDR_W | Byte address of the completing request |
| cmp_kind | input | 3 | Request kind code |
| cmp_present | input | 1 | Line is resident in the cache at completion |
| lose_valid | input | 1 | Coherence permission lost this cycle |
| lose_addr | input | ADDR_W | Byte address of the line whose permission was lost |
| rsp_valid | output | 1 | Response for last cycle's completion |
| rsp_ok | output | 1 | Success flag of that response |
| lock_valid | output | 1 | Reservation held |
| lock_line | output | ADDR_W-log2(LINE_BYTES) | Reserved line number |

## Verification
The hardest case to reach is a store-conditional or load-linked completing in the same cycle as a permission loss on the same line. It depends on both the arrival order and the state left behind by the request before it. The bench sweeps every combination of starting reservation, kind, residency, same or different line and loss target (none, same line, other line). It drives each case as one simultaneous cycle and checks the result against a reference model written from the requirements. The sweep also varies the in-line byte offset, so that the line-only comparison is tested in every case.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [2:0] {
        KIND_LOAD    = 3'd0,
        KIND_IFETCH  = 3'd1,
        KIND_STORE   = 3'd2,
        KIND_LL      = 3'd3,
        KIND_SC      = 3'd4,
        KIND_RFO     = 3'd5,
        KIND_LOCK_WR = 3'd6,
        KIND_FLUSH   = 3'd7
    } llsc_kind_e;

    typedef struct packed {
        logic is_ll;
        logic is_sc;
        logic is_plain_wr;
        logic is_read;
    } kind_class_t;

endpackage

// File: rtl/llsc_classify.sv
module llsc_classify
    import llsc_pkg::*;
(
    input  logic [2:0]  kind,
    output kind_class_t cls
);
    always_comb begin
        cls = '0;
        case (llsc_kind_e'(kind))
            KIND_LOAD, KIND_IFETCH:                    cls.is_read     = 1'b1;
            KIND_LL:                                   cls.is_ll       = 1'b1;
            KIND_SC:                                   cls.is_sc       = 1'b1;
            KIND_STORE, KIND_RFO, KIND_LOCK_WR,
            KIND_FLUSH:                                cls.is_plain_wr = 1'b1;
            default:                                   cls             = '0;
        endcase
    end
endmodule

// File: rtl/llsc_line_cmp.sv
module llsc_line_cmp #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4,
    localparam int LW    = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LW-1:0]     ref_line,
    output logic [LW-1:0]     line,
    output logic              hit
);
    assign line = addr[ADDR_W-1:OFF_W];
    assign hit  = (line == ref_line);
endmodule

// File: rtl/llsc_core.sv
module llsc_core
    import llsc_pkg::*;
#(
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_valid,
    input  logic          cmp_present,
    input  logic [LW-1:0] cmp_line,
    input  kind_class_t   cls,
    input  logic          cmp_hit,
    input  logic          lose_valid,
    input  logic          lose_hit,
    output logic          resv_valid,
    output logic [LW-1:0] resv_line,
    output logic          rsp_valid,
    output logic          rsp_ok
);
    typedef struct packed {
        logic          resv_v;
        logic [LW-1:0] resv_line;
        logic          rsp_v;
        logic          rsp_ok;
    } core_state_t;

    core_state_t state_d, state_q;
    logic        survive;

    always_comb begin
        state_d        = state_q;
        state_d.rsp_v  = cmp_valid;
        state_d.rsp_ok = cmp_valid;
        // permission loss is ordered ahead of any completion
        survive = state_q.resv_v && !(lose_valid && lose_hit);
        if (!survive) begin
            state_d.resv_v = 1'b0;
        end
        if (cmp_valid && cmp_present) begin
            if (cls.is_ll) begin
                state_d.resv_v    = 1'b1;
                state_d.resv_line = cmp_line;
            end else if (cls.is_sc) begin
                state_d.rsp_ok = survive && cmp_hit;
                if (cmp_hit) begin
                    state_d.resv_v = 1'b0;
                end
            end else if (cls.is_plain_wr && cmp_hit) begin
                state_d.resv_v = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign resv_valid = state_q.resv_v;
    assign resv_line  = state_q.resv_line;
    assign rsp_valid  = state_q.rsp_v;
    assign rsp_ok     = state_q.rsp_ok;
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 16,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LW        = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic [2:0]        cmp_kind,
    input  logic              cmp_present,
    input  logic              lose_valid,
    input  logic [ADDR_W-1:0] lose_addr,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic              lock_valid,
    output logic [LW-1:0]     lock_line
);
    kind_class_t   cls;
    logic [LW-1:0] cmp_line, lose_line;
    logic          cmp_hit, lose_hit;

    llsc_classify u_cls (.kind(cmp_kind), .cls(cls));

    llsc_line_cmp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_cmp_line (
        .addr(cmp_addr), .ref_line(lock_line), .line(cmp_line), .hit(cmp_hit)
    );

    llsc_line_cmp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_lose_line (
        .addr(lose_addr), .ref_line(lock_line), .line(lose_line), .hit(lose_hit)
    );

    llsc_core #(.LW(LW)) u_core (
        .clk(clk), .rst_n(rst_n),
        .cmp_valid(cmp_valid), .cmp_present(cmp_present), .cmp_line(cmp_line),
        .cls(cls), .cmp_hit(cmp_hit),
        .lose_valid(lose_valid), .lose_hit(lose_hit),
        .resv_valid(lock_valid), .resv_line(lock_line),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok)
    );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 16,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LW        = ADDR_W - OFF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_valid,
    input logic [ADDR_W-1:0] cmp_addr,
    input logic [2:0]        cmp_kind,
    input logic              cmp_present,
    input logic              lose_valid,
    input logic [ADDR_W-1:0] lose_addr,
    input logic              rsp_valid,
    input logic              rsp_ok,
    input logic              lock_valid,
    input logic [LW-1:0]     lock_line
);
    logic same_cmp, same_lose, is_ll, is_sc, is_rd;
    assign same_cmp  = (cmp_addr[ADDR_W-1:OFF_W] == lock_line);
    assign same_lose = (lose_addr[ADDR_W-1:OFF_W] == lock_line);
    assign is_ll     = (cmp_kind == 3'd3);
    assign is_sc     = (cmp_kind == 3'd4);
    assign is_rd     = (cmp_kind == 3'd0) || (cmp_kind == 3'd1);

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> rsp_valid); // R9
    AST_RSP_NO_OK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_ok); // R9
    AST_LL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_present && is_ll) |=>
        (lock_valid && rsp_ok && lock_line == $past(cmp_addr[ADDR_W-1:OFF_W]))); // R2
    AST_SC_NO_LOCK_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_present && is_sc && !lock_valid) |=> !rsp_ok); // R3
    AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_present && is_sc && lock_valid && same_cmp) |=> !lock_valid); // R4
    AST_ABSENT_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !cmp_present) |=> rsp_ok); // R7
    AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && is_rd && !lose_valid) |=> $stable(lock_valid)); // R8
    AST_LOSS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (lose_valid && lock_valid && same_lose && !(cmp_valid && cmp_present && is_ll))
        |=> !lock_valid); // R6
endmodule

bind llsc_monitor llsc_monitor_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (.*);

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
    localparam int AW = 16;
    localparam int OW = 4;
    localparam int LW = AW - OW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmp_valid = 1'b0;
    logic [AW-1:0] cmp_addr = '0;
    logic [2:0]    cmp_kind = '0;
    logic          cmp_present = 1'b0;
    logic          lose_valid = 1'b0;
    logic [AW-1:0] lose_addr = '0;
    logic          rsp_valid, rsp_ok, lock_valid;
    logic [LW-1:0] lock_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit            m_v = 0;
    logic [LW-1:0] m_l = '0;

    always #5 clk = ~clk;

    llsc_monitor dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic op(input logic [2:0] kind, input logic [AW-1:0] addr, input bit pres,
                      input bit lv, input logic [AW-1:0] laddr);
        bit            e_ok, e_v;
        logic [LW-1:0] e_l, line, lline;
        string         tag;
        line  = addr >> OW;
        lline = laddr >> OW;
        e_v = m_v; e_l = m_l; e_ok = 1;
        if (lv && e_v && lline == e_l) e_v = 0;
        if (pres) begin
            case (kind)
                3'd3: begin e_v = 1; e_l = line; end
                3'd4: begin e_ok = e_v && (e_l == line); if (e_l == line) e_v = 0; end
                3'd2, 3'd5, 3'd6, 3'd7: if (e_l == line) e_v = 0;
                default: ;
            endcase
        end
        if (!pres)                    tag = "R7";
        else if (lv)                  tag = "R6";
        else if (kind == 3'd3)        tag = "R2";
        else if (kind == 3'd4)        tag = "R3";
        else if (kind <= 3'd1)        tag = "R8";
        else                          tag = "R5";
        @(negedge clk);
        cmp_valid = 1; cmp_addr = addr; cmp_kind = kind; cmp_present = pres;
        lose_valid = lv; lose_addr = laddr;
        @(negedge clk);
        cmp_valid = 0; lose_valid = 0;
        check({tag, "_R9 rsp_valid"}, rsp_valid, 1);
        check({tag, " rsp_ok"}, rsp_ok, e_ok);
        check({tag, (kind == 3'd4 && pres) ? " R4" : "", " lock_valid"}, lock_valid, e_v);
        if (e_v) check({tag, " R10 lock_line"}, lock_line, e_l);
        m_v = e_v; m_l = e_l;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a_base, b_base, ca, la;
        a_base = 16'h1230;
        b_base = 16'h4560;
        repeat (2) @(negedge clk);
        // R1: reset state
        check("R1 lock_valid", lock_valid, 0);
        check("R1 rsp_valid", rsp_valid, 0);
        check("R1 rsp_ok", rsp_ok, 0);
        rst_n = 1;
        @(negedge clk);
        check("R9 idle rsp_valid", rsp_valid, 0);

        for (int st = 0; st < 2; st++)
          for (int k = 0; k < 8; k++)
            for (int p = 0; p < 2; p++)
              for (int s = 0; s < 2; s++)
                for (int l = 0; l < 3; l++) begin
                    // establish starting reservation
                    if (st == 1) op(3'd3, a_base + 16'((k + l) % 16), 1, 0, '0);
                    else begin
                        op(3'd4, a_base, 1, 0, '0);
                        op(3'd4, b_base, 1, 0, '0);
                    end
                    ca = s ? (a_base | 16'((k * 3 + p) % 16)) : b_base;
                    la = (l == 1) ? (a_base | 16'h3) : b_base;
                    op(3'(k), ca, p[0], l != 0, la);
                end

        // R10: store to other offset of reserved line clears it
        op(3'd3, 16'h7770, 1, 0, '0);
        op(3'd2, 16'h777f, 1, 0, '0);
        // R9: no response without a completion
        @(negedge clk);
        check("R9 rsp_valid idle", rsp_valid, 0);
        check("R9 rsp_ok idle", rsp_ok, 0);
        // R6: loss alone on reserved line
        op(3'd3, 16'h2220, 1, 0, '0);
        @(negedge clk);
        lose_valid = 1; lose_addr = 16'h222c;
        @(negedge clk);
        lose_valid = 0;
        check("R6 loss alone lock_valid", lock_valid, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule